// File: doc/BRIEF.md
# Configurable Programmable I/O Cell Array

This block models the digital behaviour of a row of user-configurable I/O cells in a programmable logic array. Each cell sits between one tri-state pad and the internal logic. Static configuration bits set how the cell works. On the input side the cell offers two values: the raw pad level and a stored copy of it. The storage element is either an edge-triggered flop or a level-sensitive latch, and its clock sense can be flipped. On the output side the pad is driven from the direct output signal or from a registered copy of it. The data and the enable each have their own inversion option.

Each cell takes its input clock and its output clock from one of two shared clock lines. The two choices are made separately. Every cell that touches a line must use the same clock sense on it. A per-line error flag rises when the cells disagree. A global active-low reset clears all storage at once. An asserted configuration-busy input also clears it. Configuration words are loaded on the configuration clock only while busy is high. At all other times they are frozen.

Top module: `pio_array`

## Requirements
- R1: With config bit 6 (latch mode) = 0 and bit 5 (clock invert) = 0, `qin_o[i]` takes the pad value on the rising edge of the selected input clock line and holds it otherwise.
- R2: With bit 6 = 0 and bit 5 = 1, the stored value is captured on the falling edge of the selected input line instead, and a rising edge has no effect.
- R3: With bit 6 = 1 and bit 5 = 0, `qin_o[i]` follows the pad while the selected input line is low and holds while it is high.
- R4: With bit 6 = 1 and bit 5 = 1, `qin_o[i]` follows the pad while the selected input line is high and holds while it is low.
- R5: `din_o[i]` always equals the pad level, including a level driven from outside while the cell's own driver is off.
- R6: Config bit 2 (output register) = 0 drives the pad from `out_i[i]` directly. With bit 2 = 1, the pad shows `out_i[i]` captured on the active edge of the selected output clock line, and it holds between edges.
- R7: Bit 1 inverts the pad data and bit 0 inverts `oe_i[i]`. When the effective enable is 0 the pad is high impedance.
- R8: Bit 4 selects the input clock line and bit 3 selects the output clock line (0 = `clk_line_i[0]`, 1 = `clk_line_i[1]`). An edge on the line that is not selected has no effect.
- R9: `rst_ni` low clears the input storage and the output register at once, without waiting for any clock edge.
- R10: While `cfg_busy_i` is high, all storage is held clear. Each cell's 7-bit word is `cfg_i[7*i+6 : 7*i]`. A new word is taken on a rising `cfg_clk_i` edge only while `cfg_busy_i` is high, and changes to `cfg_i` at any other time have no effect.
- R11: `err_o[k]` is 1 exactly when some cells that select line k (as input or as output clock) have clock invert set and others do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Global active-low asynchronous reset |
| cfg_clk_i | input | 1 | Configuration load clock |
| cfg_busy_i | input | 1 | Configuration in progress; clears storage and opens config loading |
| cfg_i | input | 7*N_CELLS | Configuration words, one per cell |
| clk_line_i | input | 2 | Shared clock lines |
| out_i | input | N_CELLS | Output data from internal logic |
| oe_i | input | N_CELLS | Output enable from internal logic |
| pad_io | inout | N_CELLS | Tri-state pads |
| din_o | output | N_CELLS | Direct pad input |
| qin_o | output | N_CELLS | Stored pad input |
| err_o | output | 2 | Mixed clock sense flag per shared line |

## Verification
The bench drives each of the four storage modes. It checks the opposite clock phase as well as the active one, because a flop built with the wrong edge, or a latch open in the wrong phase, shows a stored value at the wrong moment. It toggles the clock line that was not selected, to catch a cell wired to the wrong line. It also covers all sixteen combinations of the output and enable inversions. Pads meant to be high impedance are forced to both levels from outside, so a cell that wrongly drives the pad corrupts the level that is read back. Finally, it changes the configuration with busy low, to catch a design that takes new settings outside the loading window.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned N_LINES = 2;

  typedef struct packed {
    logic in_latch;  // bit 6
    logic clk_inv;   // bit 5
    logic ik_sel;    // bit 4
    logic ok_sel;    // bit 3
    logic out_reg;   // bit 2
    logic out_inv;   // bit 1
    logic oe_inv;    // bit 0
  } pio_cfg_t;

  localparam int unsigned CFG_W = $bits(pio_cfg_t);
endpackage

// File: rtl/pio_cfg_hold.sv
module pio_cfg_hold
  import pio_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  localparam int unsigned BUS_W = N_CELLS * CFG_W
) (
  input  logic                    cfg_clk_i,
  input  logic                    cfg_busy_i,
  input  logic [BUS_W-1:0]        cfg_i,
  output pio_cfg_t [N_CELLS-1:0]  cfg_o
);
  pio_cfg_t [N_CELLS-1:0] cfg_q;

  // frozen outside the configuration window
  always_ff @(posedge cfg_clk_i) begin
    if (cfg_busy_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pio_sense_chk.sv
module pio_sense_chk
  import pio_pkg::*;
#(
  parameter int unsigned N_CELLS = 4
) (
  input  pio_cfg_t [N_CELLS-1:0] cfg_i,
  output logic [N_LINES-1:0]     err_o
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic [N_CELLS-1:0] uses;
    logic [N_CELLS-1:0] inv;
    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
      assign uses[c] = (cfg_i[c].ik_sel == k[0]) || (cfg_i[c].ok_sel == k[0]);
      assign inv[c]  = cfg_i[c].clk_inv;
    end
    assign err_o[k] = (|(uses & inv)) && (|(uses & ~inv));
  end
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
(
  input  logic [N_LINES-1:0] clk_line_i,
  input  logic               clr_ni,
  input  pio_cfg_t           cfg_i,
  input  logic               out_i,
  input  logic               oe_i,
  inout  wire                pad_io,
  output logic               din_o,
  output logic               qin_o
);
  logic ik_eff, ok_eff;
  logic in_ff, in_lat, out_q;
  logic oe_eff, drv_val;

  assign ik_eff = clk_line_i[cfg_i.ik_sel] ^ cfg_i.clk_inv;
  assign ok_eff = clk_line_i[cfg_i.ok_sel] ^ cfg_i.clk_inv;
  assign din_o  = pad_io;

  always_ff @(posedge ik_eff or negedge clr_ni) begin
    if (!clr_ni) in_ff <= 1'b0;
    else         in_ff <= din_o;
  end

  // transparent while effective clock is low
  always_latch begin
    if (!clr_ni)      in_lat <= 1'b0;
    else if (!ik_eff) in_lat <= din_o;
  end

  assign qin_o = cfg_i.in_latch ? in_lat : in_ff;

  always_ff @(posedge ok_eff or negedge clr_ni) begin
    if (!clr_ni) out_q <= 1'b0;
    else         out_q <= out_i;
  end

  assign drv_val = (cfg_i.out_reg ? out_q : out_i) ^ cfg_i.out_inv;
  assign oe_eff  = oe_i ^ cfg_i.oe_inv;
  assign pad_io  = oe_eff ? drv_val : 1'bz;
endmodule

// File: rtl/pio_array.sv
module pio_array
  import pio_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  localparam int unsigned BUS_W = N_CELLS * CFG_W
) (
  input  logic                 rst_ni,
  input  logic                 cfg_clk_i,
  input  logic                 cfg_busy_i,
  input  logic [BUS_W-1:0]     cfg_i,
  input  logic [N_LINES-1:0]   clk_line_i,
  input  logic [N_CELLS-1:0]   out_i,
  input  logic [N_CELLS-1:0]   oe_i,
  inout  wire  [N_CELLS-1:0]   pad_io,
  output logic [N_CELLS-1:0]   din_o,
  output logic [N_CELLS-1:0]   qin_o,
  output logic [N_LINES-1:0]   err_o
);
  pio_cfg_t [N_CELLS-1:0] cfg_q;
  logic                   clr_n;

  assign clr_n = rst_ni & ~cfg_busy_i;

  pio_cfg_hold #(.N_CELLS(N_CELLS)) u_cfg (
    .cfg_clk_i  (cfg_clk_i),
    .cfg_busy_i (cfg_busy_i),
    .cfg_i      (cfg_i),
    .cfg_o      (cfg_q)
  );

  pio_sense_chk #(.N_CELLS(N_CELLS)) u_sense (
    .cfg_i (cfg_q),
    .err_o (err_o)
  );

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    pio_cell u_cell (
      .clk_line_i (clk_line_i),
      .clr_ni     (clr_n),
      .cfg_i      (cfg_q[c]),
      .out_i      (out_i[c]),
      .oe_i       (oe_i[c]),
      .pad_io     (pad_io[c]),
      .din_o      (din_o[c]),
      .qin_o      (qin_o[c])
    );
  end
endmodule

// File: rtl/pio_array_chk.sv
module pio_array_chk
  import pio_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  localparam int unsigned BUS_W = N_CELLS * CFG_W
) (
  input logic               rst_ni,
  input logic               cfg_clk_i,
  input logic               cfg_busy_i,
  input logic [N_LINES-1:0] clk_line_i,
  input logic [N_CELLS-1:0] out_i,
  input logic [N_CELLS-1:0] oe_i,
  input logic [N_CELLS-1:0] pad_io,
  input logic [N_CELLS-1:0] qin_o,
  input logic [N_LINES-1:0] err_o,
  input logic [BUS_W-1:0]   cfg_flat
);
  // R9
  p_rst_clear_r9: assert property (@(posedge cfg_clk_i) disable iff (cfg_busy_i)
    !rst_ni |-> (qin_o == '0));

  // R10
  p_busy_clear_r10: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cfg_busy_i |-> (qin_o == '0));

  p_cfg_frozen_r10: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (!cfg_busy_i && !$past(cfg_busy_i)) |-> $stable(cfg_flat));

  // R11
  p_err_steady_r11: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (!cfg_busy_i && !$past(cfg_busy_i)) |-> $stable(err_o));

  // R6: registered output on line 0, rising edge
  for (genvar c = 0; c < N_CELLS; c++) begin : g_oreg
    logic sel, oe_eff;
    assign sel = cfg_flat[c*CFG_W+2] && !cfg_flat[c*CFG_W+3] && !cfg_flat[c*CFG_W+5];
    assign oe_eff = oe_i[c] ^ cfg_flat[c*CFG_W+0];
    p_oreg_capture_r6: assert property (@(posedge clk_line_i[0])
      disable iff (!rst_ni || cfg_busy_i)
      sel |=> (!sel || !oe_eff || (pad_io[c] == ($past(out_i[c]) ^ cfg_flat[c*CFG_W+1]))));
  end
endmodule

bind pio_array pio_array_chk #(.N_CELLS(N_CELLS)) u_chk (
  .rst_ni     (rst_ni),
  .cfg_clk_i  (cfg_clk_i),
  .cfg_busy_i (cfg_busy_i),
  .clk_line_i (clk_line_i),
  .out_i      (out_i),
  .oe_i       (oe_i),
  .pad_io     (pad_io),
  .qin_o      (qin_o),
  .err_o      (err_o),
  .cfg_flat   (cfg_q)
);

// File: tb/pio_array_tb.sv
module pio_array_tb_top;
  localparam int N = 4;
  localparam int W = 7 * N;

  // index {out_inv, oe_inv, out_i, oe_i}; 2 = high impedance
  localparam logic [1:0] EXP_PAD [16] =
    '{2, 0, 2, 1, 0, 2, 1, 2, 2, 1, 2, 0, 1, 2, 0, 2};

  logic clk = 1'b0;
  logic rst_ni, cfg_busy;
  logic [W-1:0] cfg_bus;
  logic [1:0] line;
  logic [N-1:0] out_v, oe_v, drv_en, drv_val;
  wire  [N-1:0] pad;
  logic [N-1:0] din, qin;
  logic [1:0] err;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  for (genvar c = 0; c < N; c++) begin : g_drv
    assign pad[c] = drv_en[c] ? drv_val[c] : 1'bz;
  end

  pio_array #(.N_CELLS(N)) dut_i (
    .rst_ni (rst_ni), .cfg_clk_i (clk), .cfg_busy_i (cfg_busy), .cfg_i (cfg_bus),
    .clk_line_i (line), .out_i (out_v), .oe_i (oe_v), .pad_io (pad),
    .din_o (din), .qin_o (qin), .err_o (err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] cf(input logic lat, inv, iks, oks, oreg, oinv, einv);
    return {lat, inv, iks, oks, oreg, oinv, einv};
  endfunction

  task automatic load(input logic [6:0] c0);
    @(negedge clk);
    cfg_bus = '0;
    cfg_bus[6:0] = c0;
    cfg_busy = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    cfg_busy = 1'b0;
    #1;
  endtask

  task automatic set_line(input int k, input logic v);
    line[k] = v;
    #2;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b1; cfg_busy = 1'b0; cfg_bus = '0; line = '0;
    out_v = '0; oe_v = '0; drv_en = '1; drv_val = '0;
    #1 rst_ni = 1'b0;
    load(cf(0,0,0,0,0,0,0));
    chk("R9 reset qin", qin[0], 1'b0);
    chk("R11 no error", |err, 1'b0);
    @(negedge clk) rst_ni = 1'b1;

    // R7 table walk over inversion settings
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = i[3:0];
      load(cf(0,0,0,0,0,v[3],v[2]));
      out_v[0] = v[1]; oe_v[0] = v[0];
      if (EXP_PAD[i] == 2) begin
        drv_en[0] = 1'b1; drv_val[0] = 1'b1; #1;
        chk("R7 hi-z high", din[0], 1'b1);
        drv_val[0] = 1'b0; #1;
        chk("R7 hi-z low", din[0], 1'b0);
      end else begin
        drv_en[0] = 1'b0; #1;
        chk("R7 pad", pad[0], EXP_PAD[i][0]);
        chk("R5 din drive", din[0], EXP_PAD[i][0]);
      end
      drv_en[0] = 1'b1; oe_v[0] = 1'b0; out_v[0] = 1'b0;
    end

    // R1 rising flop, R8 line select
    load(cf(0,0,0,0,0,0,0));
    drv_val[0] = 1'b1; #1;
    chk("R1 before edge", qin[0], 1'b0);
    set_line(1, 1'b1);
    chk("R8 other line", qin[0], 1'b0);
    set_line(0, 1'b1);
    chk("R1 rise capture", qin[0], 1'b1);
    drv_val[0] = 1'b0; #1;
    chk("R1 hold high", qin[0], 1'b1);
    set_line(0, 1'b0);
    chk("R1 fall no capture", qin[0], 1'b1);
    set_line(1, 1'b0);

    // R2 falling flop
    load(cf(0,1,0,0,0,0,0));
    chk("R10 busy clears", qin[0], 1'b0);
    chk("R11 mixed line0", err[0], 1'b1);
    chk("R11 line1 clean", err[1], 1'b0);
    drv_val[0] = 1'b1; #1;
    set_line(0, 1'b1);
    chk("R2 rise ignored", qin[0], 1'b0);
    set_line(0, 1'b0);
    chk("R2 fall capture", qin[0], 1'b1);

    // R3 latch low-transparent
    load(cf(1,0,0,0,0,0,0));
    drv_val[0] = 1'b1; #1;
    chk("R3 open follow 1", qin[0], 1'b1);
    drv_val[0] = 1'b0; #1;
    chk("R3 open follow 0", qin[0], 1'b0);
    set_line(0, 1'b1);
    drv_val[0] = 1'b1; #1;
    chk("R3 closed hold", qin[0], 1'b0);
    set_line(0, 1'b0);
    chk("R3 reopen", qin[0], 1'b1);

    // R4 latch high-transparent on line 1
    load(cf(1,1,1,1,0,0,0));
    chk("R11 separate line", |err, 1'b0);
    drv_val[0] = 1'b1; #1;
    chk("R4 closed low", qin[0], 1'b0);
    set_line(1, 1'b1);
    chk("R4 open high", qin[0], 1'b1);
    drv_val[0] = 1'b0; #1;
    chk("R4 follow", qin[0], 1'b0);
    set_line(1, 1'b0);
    drv_val[0] = 1'b1; #1;
    chk("R4 hold low", qin[0], 1'b0);

    // R6 registered output on line 0
    load(cf(0,0,0,0,1,0,0));
    drv_en[0] = 1'b0; out_v[0] = 1'b1; oe_v[0] = 1'b1; #1;
    chk("R6 reg cleared", pad[0], 1'b0);
    set_line(1, 1'b1);
    chk("R8 ok line unused", pad[0], 1'b0);
    set_line(1, 1'b0);
    set_line(0, 1'b1);
    chk("R6 capture", pad[0], 1'b1);
    out_v[0] = 1'b0; #1;
    chk("R6 hold", pad[0], 1'b1);
    set_line(0, 1'b0);
    set_line(0, 1'b1);
    chk("R6 recapture", pad[0], 1'b0);
    set_line(0, 1'b0);

    // R9 async reset mid-run
    out_v[0] = 1'b1;
    set_line(0, 1'b1);
    set_line(0, 1'b0);
    oe_v[0] = 1'b0; drv_en[0] = 1'b1; drv_val[0] = 1'b1; #1;
    set_line(0, 1'b1);
    set_line(0, 1'b0);
    chk("R1 captured pre-reset", qin[0], 1'b1);
    @(negedge clk); #2;
    rst_ni = 1'b0; #1;
    chk("R9 qin cleared", qin[0], 1'b0);
    drv_en[0] = 1'b0; oe_v[0] = 1'b1; #1;
    chk("R9 out reg cleared", pad[0], 1'b0);
    @(negedge clk) rst_ni = 1'b1;

    // R10 config ignored while not busy
    @(negedge clk);
    cfg_bus[6:0] = cf(0,0,0,0,1,1,0);
    @(posedge clk); @(posedge clk); #1;
    chk("R10 no load", pad[0], 1'b0);
    load(cf(0,0,0,0,1,1,0));
    chk("R10 load in window", pad[0], 1'b1);

    // R5 external level on idle cell
    drv_val[2] = 1'b1; #1;
    chk("R5 din ext 1", din[2], 1'b1);
    drv_val[2] = 1'b0; #1;
    chk("R5 din ext 0", din[2], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule